// File: doc/BRIEF.md
# Return Address Stack Predictor

This block is a small hardware stack that predicts where a function return will land. When a call goes down the pipeline, the front end pushes the call's return address onto the stack. This happens in the same cycle that the link register (register 31) receives that address. When a return is fetched, the front end pops the stack. The entry on top is offered to fetch as the predicted target, together with a valid bit. When the stack is empty the valid bit is low, and fetch falls back to its sequential next address.

The stack holds a fixed number of entries. A parameter chooses what happens on a push to a full stack. In wrap mode the newest address overwrites the oldest one in circular fashion. In refuse mode the push is dropped and the stored entries are kept. In both modes a sticky overflow flag records that an address was lost. Misprediction recovery drives a clear input, for example after a long jump leaves the stack out of step with the program. The clear empties the stack and lowers the flag.

Top module: `ras_predictor`

## Requirements
- R1: After a synchronous reset, the occupancy count is 0, the prediction valid output is low and the overflow flag is low.
- R2: A push alone on a non-full stack raises the count by one. From the next cycle the predicted address equals the pushed address and valid is high.
- R3: A pop alone on a non-empty stack lowers the count by one, and the predicted address becomes the previously pushed entry (last in, first out). Valid goes low when the count reaches 0.
- R4: A pop on an empty stack has no effect: the count stays 0 and valid stays low.
- R5: A push and a pop in the same cycle replace the top entry with the pushed address and leave the count unchanged. On an empty stack this leaves the count at 0 and valid low.
- R6: The count never exceeds the depth (8 by default) and saturates there on further pushes.
- R7: With the wrap policy (OVF_POLICY = OVF_WRAP), a push on a full stack makes the pushed address the top entry and overwrites the oldest entry. Popping then yields the newest DEPTH addresses.
- R8: With the refuse policy (OVF_POLICY = OVF_REFUSE), a push on a full stack is dropped. The top entry and all stored entries are unchanged.
- R9: A push without a pop on a full stack sets the overflow flag under either policy. The flag stays set until a clear or a reset.
- R10: The clear input empties the stack (count 0, valid low) and lowers the overflow flag in the next cycle. It takes priority over a push or pop in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Clear request from misprediction recovery |
| push_i | input | 1 | Call seen: push the return address |
| push_addr_i | input | AW (32) | Return address to push |
| pop_i | input | 1 | Return seen: pop the top entry |
| pred_addr_o | output | AW (32) | Predicted return target (top entry) |
| pred_valid_o | output | 1 | High when the stack holds at least one entry |
| count_o | output | clog2(DEPTH+1) (4) | Number of valid entries |
| ovf_o | output | 1 | Sticky flag: an address was lost to overflow |

## Verification
The bench builds two instances with the default depth of 8 and 32-bit addresses: one with the wrap policy and one with the refuse policy. Both receive the same stimulus. A depth of 8 lets nine pushes drive both copies into overflow within a few cycles. The two instances must then disagree on the top entry, and each drain of eight pops exposes which entry was kept or overwritten. The small depth also makes the pointer wrap at both ends, and lets a clear after overflow be checked against a stack that was completely full.

// File: rtl/ras_pkg.sv
package ras_pkg;

    typedef enum logic {
        OVF_WRAP   = 1'b0,
        OVF_REFUSE = 1'b1
    } ovf_policy_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PUSH,
        ACT_POP,
        ACT_SWAP,
        ACT_PUSH_WRAP,
        ACT_PUSH_DROP,
        ACT_CLEAR
    } ras_act_e;

    typedef struct packed {
        logic flush;
        logic push;
        logic pop;
    } ras_req_t;

    // Resolve one cycle's requests into a single stack action.
    function automatic ras_act_e ras_classify(ras_req_t req, logic empty,
                                              logic full, ovf_policy_e pol);
        ras_act_e act;
        if (req.flush)
            act = ACT_CLEAR;
        else if (req.push && req.pop)
            act = empty ? ACT_IDLE : ACT_SWAP;
        else if (req.push)
            act = !full ? ACT_PUSH
                        : ((pol == OVF_WRAP) ? ACT_PUSH_WRAP : ACT_PUSH_DROP);
        else if (req.pop)
            act = empty ? ACT_IDLE : ACT_POP;
        else
            act = ACT_IDLE;
        return act;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
#(
    parameter int          DEPTH      = 8,
    parameter ovf_policy_e OVF_POLICY = OVF_WRAP,
    localparam int         PW         = $clog2(DEPTH),
    localparam int         CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  ras_req_t      req_i,
    output logic [PW-1:0] top_o,
    output logic [CW-1:0] cnt_o,
    output logic          ovf_o,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [PW-1:0] top_q, top_d, top_up, top_dn;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          ovf_q, ovf_d;
    ras_act_e      act;

    assign top_up = (top_q == LAST)     ? '0   : top_q + PW'(1);
    assign top_dn = (top_q == PW'(0))   ? LAST : top_q - PW'(1);

    assign act = ras_classify(req_i, cnt_q == CW'(0), cnt_q == FULL, OVF_POLICY);

    always_comb begin
        top_d    = top_q;
        cnt_d    = cnt_q;
        ovf_d    = ovf_q;
        wr_en_o  = 1'b0;
        wr_idx_o = top_up;
        case (act)
            ACT_CLEAR: begin
                top_d = LAST;
                cnt_d = '0;
                ovf_d = 1'b0;
            end
            ACT_PUSH: begin
                top_d   = top_up;
                cnt_d   = cnt_q + CW'(1);
                wr_en_o = 1'b1;
            end
            ACT_POP: begin
                top_d = top_dn;
                cnt_d = cnt_q - CW'(1);
            end
            ACT_SWAP: begin
                wr_en_o  = 1'b1;
                wr_idx_o = top_q;
            end
            ACT_PUSH_WRAP: begin
                top_d   = top_up;
                ovf_d   = 1'b1;
                wr_en_o = 1'b1;
            end
            ACT_PUSH_DROP: begin
                ovf_d = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= LAST;
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            top_q <= top_d;
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end
    end

    assign top_o = top_q;
    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int  DEPTH = 8,
    parameter int  AW    = 32,
    localparam int PW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [AW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot_q[i] <= '0;
            else if (wr_en_i && (wr_idx_i == PW'(i)))
                slot_q[i] <= wr_data_i;
        end
    end

    assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ras_predictor.sv
module ras_predictor
    import ras_pkg::*;
#(
    parameter int          DEPTH      = 8,
    parameter int          AW         = 32,
    parameter ovf_policy_e OVF_POLICY = OVF_WRAP,
    localparam int         PW         = $clog2(DEPTH),
    localparam int         CW         = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    output logic [AW-1:0] pred_addr_o,
    output logic          pred_valid_o,
    output logic [CW-1:0] count_o,
    output logic          ovf_o
);

    ras_req_t      req;
    logic [PW-1:0] top_idx;
    logic [PW-1:0] wr_idx;
    logic          wr_en;

    assign req = '{flush: flush_i, push: push_i, pop: pop_i};

    ras_ctrl #(
        .DEPTH      (DEPTH),
        .OVF_POLICY (OVF_POLICY)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .top_o    (top_idx),
        .cnt_o    (count_o),
        .ovf_o    (ovf_o),
        .wr_en_o  (wr_en),
        .wr_idx_o (wr_idx)
    );

    ras_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (push_addr_i),
        .rd_idx_i  (top_idx),
        .rd_data_o (pred_addr_o)
    );

    assign pred_valid_o = (count_o != CW'(0));

endmodule

// File: rtl/ras_predictor_chk.sv
module ras_predictor_chk
    import ras_pkg::*;
#(
    parameter int          DEPTH      = 8,
    parameter int          AW         = 32,
    parameter ovf_policy_e OVF_POLICY = OVF_WRAP,
    localparam int         CW         = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          flush_i,
    input logic          push_i,
    input logic [AW-1:0] push_addr_i,
    input logic          pop_i,
    input logic [AW-1:0] pred_addr_o,
    input logic          pred_valid_o,
    input logic [CW-1:0] count_o,
    input logic          ovf_o
);

    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic push_only, pop_only, both;
    assign push_only = push_i && !pop_i && !flush_i;
    assign pop_only  = pop_i && !push_i && !flush_i;
    assign both      = push_i && pop_i && !flush_i;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (count_o == '0 && !pred_valid_o && !ovf_o)); // R1

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push_only && count_o != FULL) |=>
        (count_o == $past(count_o) + CW'(1) && pred_valid_o
         && pred_addr_o == $past(push_addr_i))); // R2

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (rst)
        (pop_only && count_o != '0) |=> (count_o == $past(count_o) - CW'(1))); // R3

    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (rst)
        (pop_only && count_o == '0) |=> (count_o == '0 && !pred_valid_o)); // R4

    AST_SWAP_TOP: assert property (@(posedge clk) disable iff (rst)
        (both && count_o != '0) |=>
        ($stable(count_o) && pred_addr_o == $past(push_addr_i))); // R5

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        count_o <= FULL); // R6

    AST_FULL_PUSH_FLAG: assert property (@(posedge clk) disable iff (rst)
        (push_only && count_o == FULL) |=> (count_o == FULL && ovf_o)); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ovf_o && !flush_i) |=> ovf_o); // R9

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (count_o == '0 && !ovf_o && !pred_valid_o)); // R10

    if (OVF_POLICY == OVF_WRAP) begin : g_wrap
        AST_WRAP_TOP: assert property (@(posedge clk) disable iff (rst)
            (push_only && count_o == FULL) |=>
            (pred_addr_o == $past(push_addr_i))); // R7
    end else begin : g_refuse
        AST_REFUSE_TOP: assert property (@(posedge clk) disable iff (rst)
            (push_only && count_o == FULL) |=> $stable(pred_addr_o)); // R8
    end

endmodule

bind ras_predictor ras_predictor_chk #(
    .DEPTH      (DEPTH),
    .AW         (AW),
    .OVF_POLICY (OVF_POLICY)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .push_i       (push_i),
    .push_addr_i  (push_addr_i),
    .pop_i        (pop_i),
    .pred_addr_o  (pred_addr_o),
    .pred_valid_o (pred_valid_o),
    .count_o      (count_o),
    .ovf_o        (ovf_o)
);

// File: tb/ras_predictor_bench.sv
module ras_predictor_bench;
    import ras_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush_i = 1'b0, push_i = 1'b0, pop_i = 1'b0;
    logic [31:0] push_addr_i = '0;

    logic [31:0] w_addr, r_addr;
    logic        w_val, r_val, w_ovf, r_ovf;
    logic [3:0]  w_cnt, r_cnt;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ras_predictor #(.DEPTH(8), .AW(32), .OVF_POLICY(OVF_WRAP)) u_ras_predictor (
        .clk(clk), .rst(rst), .flush_i(flush_i), .push_i(push_i),
        .push_addr_i(push_addr_i), .pop_i(pop_i), .pred_addr_o(w_addr),
        .pred_valid_o(w_val), .count_o(w_cnt), .ovf_o(w_ovf));

    ras_predictor #(.DEPTH(8), .AW(32), .OVF_POLICY(OVF_REFUSE)) u_ras_refuse (
        .clk(clk), .rst(rst), .flush_i(flush_i), .push_i(push_i),
        .push_addr_i(push_addr_i), .pop_i(pop_i), .pred_addr_o(r_addr),
        .pred_valid_o(r_val), .count_o(r_cnt), .ovf_o(r_ovf));

    typedef struct packed {
        logic        pu;
        logic        po;
        logic        fl;
        logic [31:0] a;
        logic        ev;
        logic [31:0] ea;
        logic [3:0]  ec;
        logic        eo;
        logic [3:0]  rq;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 32'h100, 1'b1, 32'h100, 4'd1, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b0, 1'b0, 32'h200, 1'b1, 32'h200, 4'd2, 1'b0, 4'd2}, // R2
        '{1'b0, 1'b1, 1'b0, 32'h0,   1'b1, 32'h100, 4'd1, 1'b0, 4'd3}, // R3
        '{1'b1, 1'b1, 1'b0, 32'h300, 1'b1, 32'h300, 4'd1, 1'b0, 4'd5}, // R5
        '{1'b0, 1'b1, 1'b0, 32'h0,   1'b0, 32'h0,   4'd0, 1'b0, 4'd3}, // R3
        '{1'b0, 1'b1, 1'b0, 32'h0,   1'b0, 32'h0,   4'd0, 1'b0, 4'd4}, // R4
        '{1'b1, 1'b1, 1'b0, 32'h400, 1'b0, 32'h0,   4'd0, 1'b0, 4'd5}, // R5
        '{1'b1, 1'b0, 1'b0, 32'h600, 1'b1, 32'h600, 4'd1, 1'b0, 4'd2}, // R2
        '{1'b1, 1'b1, 1'b1, 32'h500, 1'b0, 32'h0,   4'd0, 1'b0, 4'd10} // R10
    };

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one cycle of requests; return at the next falling edge.
    task automatic cyc(logic pu, logic po, logic fl, logic [31:0] a);
        push_i = pu; pop_i = po; flush_i = fl; push_addr_i = a;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; flush_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset count", 32'(w_cnt), 32'd0);
        chk("R1 reset valid", 32'(w_val), 32'd0);
        chk("R1 reset ovf",   32'(w_ovf), 32'd0);
        chk("R1 reset count refuse", 32'(r_cnt), 32'd0);

        for (int i = 0; i < NV; i++) begin
            cyc(VECS[i].pu, VECS[i].po, VECS[i].fl, VECS[i].a);
            chk($sformatf("R%0d vec %0d valid", VECS[i].rq, i), 32'(w_val), 32'(VECS[i].ev));
            chk($sformatf("R%0d vec %0d count", VECS[i].rq, i), 32'(w_cnt), 32'(VECS[i].ec));
            chk($sformatf("R%0d vec %0d ovf", VECS[i].rq, i), 32'(w_ovf), 32'(VECS[i].eo));
            if (VECS[i].ev)
                chk($sformatf("R%0d vec %0d addr", VECS[i].rq, i), w_addr, VECS[i].ea);
        end

        // Fill both stacks to the depth.
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, 32'h1000 + 32'(i * 4));
        chk("R6 full count wrap",   32'(w_cnt), 32'd8);
        chk("R6 full count refuse", 32'(r_cnt), 32'd8);
        chk("R9 no ovf at full",    32'(w_ovf), 32'd0);

        // Ninth push: overflow.
        cyc(1'b1, 1'b0, 1'b0, 32'h2000);
        chk("R6 saturate wrap",   32'(w_cnt), 32'd8);
        chk("R6 saturate refuse", 32'(r_cnt), 32'd8);
        chk("R9 ovf wrap",        32'(w_ovf), 32'd1);
        chk("R9 ovf refuse",      32'(r_ovf), 32'd1);
        chk("R7 wrap top newest", w_addr, 32'h2000);
        chk("R8 refuse top kept", r_addr, 32'h101C);

        // Drain: wrap holds 0x1004..0x101C plus 0x2000; refuse 0x1000..0x101C.
        for (int k = 1; k <= 8; k++) begin
            cyc(1'b0, 1'b1, 1'b0, 32'h0);
            if (k < 8) begin
                chk($sformatf("R7 wrap pop %0d", k), w_addr, 32'h1000 + 32'((8 - k) * 4));
                chk($sformatf("R8 refuse pop %0d", k), r_addr, 32'h1000 + 32'((7 - k) * 4));
            end
        end
        chk("R7 wrap drained valid",   32'(w_val), 32'd0);
        chk("R8 refuse drained valid", 32'(r_val), 32'd0);
        chk("R9 ovf sticky wrap",      32'(w_ovf), 32'd1);
        chk("R9 ovf sticky refuse",    32'(r_ovf), 32'd1);

        // Clear after overflow with a competing push.
        cyc(1'b1, 1'b0, 1'b0, 32'h3000);
        cyc(1'b1, 1'b0, 1'b1, 32'h3004);
        chk("R10 clear count", 32'(w_cnt), 32'd0);
        chk("R10 clear valid", 32'(r_val), 32'd0);
        chk("R10 clear ovf",   32'(w_ovf), 32'd0);
        chk("R10 clear ovf refuse", 32'(r_ovf), 32'd0);

        // Reset in mid-run.
        cyc(1'b1, 1'b0, 1'b0, 32'h4000);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 mid reset count", 32'(w_cnt), 32'd0);
        chk("R1 mid reset valid", 32'(w_val), 32'd0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule